// File: doc/BRIEF.md
# Non-Retriggerable Clocked One-Shot with Clear

This block is a single-channel monostable pulse generator that runs entirely on the system clock. It watches three control inputs: an active-low trigger input, an active-high trigger input, and an active-low clear. A qualified transition on any of them starts one output pulse whose length, in clock cycles, is read from a width input at the moment the trigger is accepted. The pulse appears on a true output and on its complement. A two-channel arrangement is built from two instances.

Each control input first passes through a two-stage synchronizer. A history register then detects edges by comparing each synchronized level with its value one clock earlier. Three qualification rules turn those edges into a single trigger strobe, and a small state machine acts on it.

The state machine has three states. `ST_IDLE` waits for a trigger. `ST_PULSE` drives the output high while a down-counter runs. `ST_GAP` holds the output low for exactly one cycle when a trigger lands on the final pulse cycle. The transitions are:

- idle-to-pulse, on an accepted trigger;
- pulse-to-idle, on the last count with no trigger;
- pulse-to-gap, on the last count with a trigger;
- gap-to-pulse, unconditionally;
- any-to-idle, whenever the synchronized clear is low.

A trigger that arrives in the middle of a pulse is ignored. A low clear ends any pulse at once.

Top module: `oneshot_pulse`

## Requirements
- R1: During and directly after the synchronous active-high reset `rst`, `q` is 0 and `qn` is 1.
- R2: `qn` equals the inverse of `q` on every cycle.
- R3: With `b_in` high and `clr_n_in` high, a high-to-low change of `a_in` makes `q` rise at the third rising clock edge after the change. `q` then stays high for exactly `width` cycles.
- R4: With `a_in` low and `clr_n_in` high, a low-to-high change of `b_in` starts a pulse with the same timing as R3.
- R5: A low-to-high change of `clr_n_in` starts a pulse with the same timing as R3, provided `a_in` is low, `b_in` is high, and `b_in` rose while the clear was low. If `b_in` was already high when the clear went low, releasing the clear starts nothing.
- R6: A low `clr_n_in` forces `q` low and `qn` high from the second rising clock edge after it falls. It ends any pulse in progress, and the remaining count does not resume when the clear is released.
- R7: The pulse is non-retriggerable. A qualified trigger during a pulse, other than on its last cycle, neither lengthens that pulse nor starts a later one.
- R8: `width` is sampled when the trigger is accepted, and later changes do not affect the running pulse. A `width` of 0 gives a one-cycle pulse.
- R9: A trigger detected on the last high cycle of a pulse is accepted. `q` is low for exactly one cycle and then high for the newly sampled width.
- R10: These leave the outputs idle: a rise of `b_in` while `a_in` is high, a fall of `a_in` while `b_in` is low, and any change of `a_in` or `b_in` while the clear is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 1 | Trigger input that acts on its falling transition |
| b_in | input | 1 | Trigger input that acts on its rising transition |
| clr_n_in | input | 1 | Active-low clear; its rising transition can also trigger |
| width | input | WB | Pulse length in clock cycles (0 is treated as 1) |
| q | output | 1 | Pulse output, active high |
| qn | output | 1 | Complement of `q` |

## Verification
The hardest case to reach is a trigger that lands on exactly the last high cycle of a pulse. To do that, the stimulus must place an edge so that it clears the two synchronizer stages and the history stage in the same cycle the counter reaches one. The bench drives every input at the falling clock edge and scripts each scenario cycle by cycle. It counts falling edges from the first trigger and places the second falling edge of `a_in` four edges later, with a short width. The clear-as-trigger rule is also hard to reach, because it depends on the order of events. The bench reaches it by holding the clear low, raising `b_in` to arm the rule, and only then releasing the clear. It then repeats the sequence with `b_in` raised before the clear falls, to show that no pulse starts.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } state_t;

    // Idle levels of the three control inputs, packed as {clr_n, b, a}
    localparam logic [2:0] IDLE_LEVELS = 3'b101;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig (
    input  logic clk,
    input  logic rst,
    input  logic a_s,
    input  logic b_s,
    input  logic clr_s,
    output logic trig
);

    logic a_prev, b_prev, clr_prev;
    logic armed_q, armed_d;
    logic fall_a, rise_b, rise_clr;
    logic trig_a, trig_b, trig_clr;

    // One-cycle edge history
    always_ff @(posedge clk) begin
        if (rst) begin
            a_prev   <= oneshot_pkg::IDLE_LEVELS[0];
            b_prev   <= oneshot_pkg::IDLE_LEVELS[1];
            clr_prev <= oneshot_pkg::IDLE_LEVELS[2];
        end else begin
            a_prev   <= a_s;
            b_prev   <= b_s;
            clr_prev <= clr_s;
        end
    end

    always_comb begin
        fall_a   = a_prev & ~a_s;
        rise_b   = ~b_prev & b_s;
        rise_clr = ~clr_prev & clr_s;
    end

    // Armed when b rose while clear was low; dropped if b falls or clear rises
    always_comb begin
        if (clr_s || !b_s) armed_d = 1'b0;
        else               armed_d = armed_q | rise_b;
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end

    always_comb begin
        trig_a   = fall_a   & b_s   & clr_s;
        trig_b   = rise_b   & ~a_s  & clr_s;
        trig_clr = rise_clr & ~a_s  & b_s & armed_q;
        trig     = trig_a | trig_b | trig_clr;
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int WB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [WB-1:0] load_val,
    input  logic          dec,
    output logic [WB-1:0] cnt,
    output logic          last
);

    localparam logic [WB-1:0] ONE = WB'(1);

    logic [WB-1:0] start_val;

    always_comb begin
        start_val = (load_val == '0) ? ONE : load_val;
        last      = (cnt == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (load)           cnt <= start_val;
        else if (dec && cnt != '0) cnt <= cnt - ONE;
    end

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse #(
    parameter int WB          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_in,
    input  logic          b_in,
    input  logic          clr_n_in,
    input  logic [WB-1:0] width,
    output logic          q,
    output logic          qn
);
    import oneshot_pkg::*;

    localparam int NIN = 3;

    logic [NIN-1:0] raw_in, sync_out;
    logic           a_s, b_s, clr_s;
    logic           trig, accept, last;
    logic [WB-1:0]  cnt;
    state_t         state_q, state_d;

    assign raw_in = {clr_n_in, b_in, a_in};

    oneshot_sync #(
        .N      (NIN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE_LEVELS)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_in),
        .q  (sync_out)
    );

    assign a_s   = sync_out[0];
    assign b_s   = sync_out[1];
    assign clr_s = sync_out[2];

    oneshot_trig i_trig (
        .clk  (clk),
        .rst  (rst),
        .a_s  (a_s),
        .b_s  (b_s),
        .clr_s(clr_s),
        .trig (trig)
    );

    // A trigger is taken only when idle or on the final pulse cycle
    always_comb begin
        accept = trig && ((state_q == ST_IDLE) || (state_q == ST_PULSE && last));
    end

    oneshot_timer #(
        .WB(WB)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (~clr_s),
        .load    (accept),
        .load_val(width),
        .dec     (state_q == ST_PULSE),
        .cnt     (cnt),
        .last    (last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (last) state_d = trig ? ST_GAP : ST_IDLE;
            end
            ST_GAP: begin
                state_d = ST_PULSE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!clr_s) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Outputs; the synchronized clear masks the pulse at once
    always_comb begin
        q  = (state_q == ST_PULSE) && clr_s;
        qn = ~q;
    end

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
    parameter int WB = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 q,
    input logic                 qn,
    input oneshot_pkg::state_t  state,
    input logic                 clr_s,
    input logic                 trig,
    input logic [WB-1:0]        cnt,
    input logic                 last
);
    import oneshot_pkg::*;

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!q && qn));

    p_complement_r2: assert property (@(posedge clk) disable iff (rst) qn == ~q);

    p_start_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_PULSE) |-> ($past(trig) || $past(state) == ST_GAP));

    p_clear_masks_r6: assert property (@(posedge clk) disable iff (rst)
        !clr_s |-> (!q && qn));

    p_clear_ends_r6: assert property (@(posedge clk) disable iff (rst)
        !clr_s |=> state == ST_IDLE);

    p_no_retrig_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE && !last && clr_s) |=>
            (state == ST_PULSE && cnt == $past(cnt) - WB'(1)));

    p_gap_low_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> !q);

    p_gap_next_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && clr_s) |=> state == ST_PULSE);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !trig) |=> state == ST_IDLE);

endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WB(WB)) i_chk (
    .clk  (clk),
    .rst  (rst),
    .q    (q),
    .qn   (qn),
    .state(state_q),
    .clr_s(clr_s),
    .trig (trig),
    .cnt  (cnt),
    .last (last)
);

// File: tb/test_oneshot_pulse.sv
module test_oneshot_pulse;

    localparam int WB = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          a, b, clr_n;
    logic [WB-1:0] width;
    logic          q, qn;
    int            checks = 0;
    int            fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    oneshot_pulse #(.WB(WB), .SYNC_STAGES(2)) i_oneshot_pulse (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a),
        .b_in    (b),
        .clr_n_in(clr_n),
        .width   (width),
        .q       (q),
        .qn      (qn)
    );

    task automatic check_q(input logic exp, input string tag);
        checks++;
        if (q !== exp || qn !== ~exp) begin
            fails++;
            $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b at %0t", tag, q, qn, exp, ~exp, $time);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_q(1'b0, tag);
        end
    endtask

    // Called right after driving the trigger at a falling edge
    task automatic expect_pulse(input int w, input string tag);
        int len;
        for (int i = 1; i <= 2; i++) begin
            @(negedge clk);
            check_q(1'b0, tag);
        end
        @(negedge clk);
        check_q(1'b1, tag);
        len = 0;
        while (q === 1'b1 && len < 300) begin
            len++;
            @(negedge clk);
        end
        checks++;
        if (len != w) begin
            fails++;
            $display("FAIL %s: pulse length %0d expected %0d", tag, len, w);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        clr_n = 1'b1;
        b     = 1'b0;
        quiet(4, "R10 idle setup");
        a = 1'b1;
        quiet(4, "R10 idle setup");
    endtask

    task automatic t_reset();
        rst = 1'b1; a = 1'b1; b = 1'b0; clr_n = 1'b1; width = 8'd4;
        repeat (4) @(negedge clk);
        check_q(1'b0, "R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_q(1'b0, "R1 after reset");
        quiet(4, "R1 R2 idle after reset");
    endtask

    task automatic t_trig_a();
        go_idle();
        b = 1'b1;                       // b rises while a high: no pulse
        quiet(5, "R10 b rise with a high");
        width = 8'd5;
        a = 1'b0;
        expect_pulse(5, "R3 falling a");
    endtask

    task automatic t_trig_b();
        go_idle();
        a = 1'b0;                       // a falls while b low: no pulse
        quiet(5, "R10 a fall with b low");
        width = 8'd7;
        b = 1'b1;
        expect_pulse(7, "R4 rising b");
    endtask

    task automatic t_width_zero();
        go_idle();
        b = 1'b1;
        quiet(4, "R10 setup");
        width = 8'd0;
        a = 1'b0;
        expect_pulse(1, "R8 width zero");
    endtask

    task automatic t_clear_trig();
        go_idle();
        a = 1'b0;
        quiet(4, "R10 setup");
        clr_n = 1'b0;
        quiet(4, "R6 clear low idle");
        b = 1'b1;                       // arms the clear trigger
        quiet(5, "R10 b rise under clear");
        width = 8'd6;
        clr_n = 1'b1;
        expect_pulse(6, "R5 clear release trigger");
        // b already high before clear falls: release must not trigger
        clr_n = 1'b0;
        quiet(5, "R6 clear low");
        clr_n = 1'b1;
        quiet(8, "R5 no trigger without arming");
    endtask

    task automatic t_edges_under_clear();
        go_idle();
        clr_n = 1'b0;
        quiet(4, "R6 clear low");
        b = 1'b1;
        quiet(4, "R10 b rise under clear");
        a = 1'b0;
        quiet(6, "R10 a fall under clear");
        a = 1'b1;
        quiet(4, "R10 a rise under clear");
        clr_n = 1'b1;
        quiet(6, "R10 release with a high");
    endtask

    task automatic t_truncate();
        go_idle();
        b = 1'b1;
        quiet(4, "R10 setup");
        width = 8'd50;
        a = 1'b0;
        for (int n = 1; n <= 14; n++) begin
            @(negedge clk);
            check_q((n >= 3 && n <= 8), "R6 clear truncates pulse");
            if (n == 7) clr_n = 1'b0;
            if (n == 10) a = 1'b1;
        end
        clr_n = 1'b1;
        quiet(60, "R6 count does not resume");
    endtask

    task automatic t_no_retrig();
        go_idle();
        b = 1'b1;
        quiet(4, "R10 setup");
        width = 8'd20;
        a = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            check_q((n >= 3 && n <= 22), "R7 non-retriggerable");
            if (n == 5) a = 1'b1;
            if (n == 8) a = 1'b0;
            if (n == 9) width = 8'd3;
        end
        quiet(6, "R7 no late pulse");
    endtask

    task automatic t_end_trigger();
        go_idle();
        b = 1'b1;
        quiet(4, "R10 setup");
        width = 8'd4;
        a = 1'b0;
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            check_q(((n >= 3 && n <= 6) || (n >= 8 && n <= 10)), "R9 R8 trigger on last cycle");
            if (n == 1) a = 1'b1;
            if (n == 4) begin
                a     = 1'b0;
                width = 8'd3;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_trig_a();
        t_trig_b();
        t_width_zero();
        t_clear_trig();
        t_edges_under_clear();
        t_truncate();
        t_no_retrig();
        t_end_trigger();
        quiet(4, "R2 final idle");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule